// File: doc/BRIEF.md
# Interrupt presentation controller

This block is the per-processor presentation stage of a two-level interrupt controller. It holds only one pending interrupt at a time, the most favoured one. It does not queue. It takes presentation requests from the source controllers and drives one interrupt line into the processor. It also answers the processor's register operations: accept, end-of-interrupt, set priority, set the inter-processor-interrupt (IPI) request, and poll.

A request that loses, or a pending interrupt that is displaced, goes back to the source controller that owns it as a reject notification. The sources offer it again when the block raises a resend notification. End-of-interrupt writes are forwarded to the sources as EOI notifications.

Priorities are 8-bit numbers, and a lower number is more favoured. The value 0xFF means least favoured, or nothing pending.

The state word is 32 bits wide:
- Bits 31:24 hold the current processor priority.
- Bits 23:0 hold the pending source number. A source number of zero means nothing is pending.

Source number `IPI_NUM` (default 2) is reserved for the IPI.

Top module: `irq_present`

## Requirements
- R1: After reset the state word is 0x00000000, the pending priority is 0xFF, the IPI request is 0xFF, `irq_out` is low and no notification is active.
- R2: A poll strobe returns, one cycle later on `rd_valid`, the state word `{processor priority[31:24], source[23:0]}` on `rd_word` and the IPI request on `rd_mfrr`. It changes no state.
- R3: A request is refused if either holds:
  - its priority is greater than or equal to the processor priority;
  - a source is already pending whose priority is less than or equal to the request's priority.
  A refused request is reported on the request reject channel with its own source and owner.
- R4: When a request is taken:
  - any pending interrupt that has an owner is reported on the request reject channel;
  - the new source, priority and owner are latched;
  - `irq_out` rises.
  Displacing a pending IPI produces no reject.
- R5: An accept returns the state word as it stood before the accept. It then:
  - lowers `irq_out`;
  - loads the pending priority into the processor priority field and clears the source number;
  - sets the pending priority to 0xFF and clears the owner.
- R6: An end-of-interrupt write takes the processor priority from bits 31:24 of `op_wdata`. It raises `eoi_valid` with `eoi_src` equal to bits 23:0. If no source is pending it also issues a resend.
- R7: Writing a processor priority lower than the current one drops the pending interrupt if the new value is less than or equal to the pending priority. Dropping means:
  - the source is cleared;
  - the pending priority becomes 0xFF;
  - `irq_out` falls;
  - the owner, if any, is reported on the operation reject channel.
- R8: Writing a processor priority equal to or greater than the current one, with no source pending, raises `resend_valid`.
- R9: Writing an IPI request value below the processor priority runs the IPI check. The check leaves state alone if a source is pending at a priority less than or equal to the IPI request. Otherwise it:
  - rejects any owned pending source on the operation reject channel;
  - loads source `IPI_NUM` with the IPI request as the pending priority;
  - raises `irq_out`.
- R10: Every resend first runs the IPI check when the IPI request is below the processor priority.
- R11: When a processor operation and a request fall in the same cycle, the operation is applied first. The request is then judged against the updated state. Each has its own reject channel.
- R12: `irq_out` is high exactly when the pending source number is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_accept | input | 1 | Accept strobe (highest strobe priority) |
| op_eoi | input | 1 | End-of-interrupt strobe |
| op_cppr | input | 1 | Processor priority write strobe |
| op_mfrr | input | 1 | IPI request write strobe |
| op_poll | input | 1 | Poll strobe (lowest strobe priority) |
| op_wdata | input | 32 | Operation data: full word for EOI, bits 7:0 for priority writes |
| req_valid | input | 1 | Presentation request from a source controller |
| req_src | input | 24 | Requested source number (non-zero) |
| req_prio | input | 8 | Requested priority |
| req_owner | input | OWNER_W | Index of the requesting source controller |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read data valid for accept or poll |
| rd_word | output | 32 | State word returned by accept or poll |
| rd_mfrr | output | 8 | IPI request returned by poll |
| rej_op_valid | output | 1 | Reject caused by a processor operation |
| rej_op_src | output | 24 | Source number of that reject |
| rej_op_owner | output | OWNER_W | Owner of that reject |
| rej_req_valid | output | 1 | Reject caused by a presentation request |
| rej_req_src | output | 24 | Source number of that reject |
| rej_req_owner | output | OWNER_W | Owner of that reject |
| eoi_valid | output | 1 | EOI notification to the sources |
| eoi_src | output | 24 | Source number being ended |
| resend_valid | output | 1 | Resend notification to the sources |

## Verification
A processor operation and a source request can land in the same cycle.

- The first case pairs a more favoured processor-priority write with a request. The write drops the pending source, and the request is then taken against the new priority. The bench expects a reject on the operation channel only, and a poll that shows the new source.
- The second case pairs an accept with a request. The accept moves the processor priority to the old pending priority, which refuses the request. The bench expects the accept to read back the old word and the request to come back on the request channel.

Both reject channels are compared with values computed from the rules above.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_NONE = '1;
endpackage

// File: rtl/irqp_ipi_chk.sv
module irqp_ipi_chk
    import irqp_pkg::*;
#(
    parameter int OWNER_W = 2,
    parameter int IPI_NUM = 2
) (
    input  logic               en_i,
    input  src_t               xisr_i,
    input  prio_t              pprio_i,
    input  logic               own_v_i,
    input  logic [OWNER_W-1:0] own_i,
    input  prio_t              mfrr_i,
    output src_t               xisr_o,
    output prio_t              pprio_o,
    output logic               own_v_o,
    output logic               raise_o,
    output logic               rej_v_o,
    output src_t               rej_src_o,
    output logic [OWNER_W-1:0] rej_own_o
);
    localparam src_t IPI_SRC = src_t'(IPI_NUM);

    logic keep;

    always_comb begin
        keep      = (xisr_i != '0) && (pprio_i <= mfrr_i);
        xisr_o    = xisr_i;
        pprio_o   = pprio_i;
        own_v_o   = own_v_i;
        raise_o   = 1'b0;
        rej_v_o   = 1'b0;
        rej_src_o = xisr_i;
        rej_own_o = own_i;
        if (en_i && !keep) begin
            rej_v_o = (xisr_i != '0) && own_v_i;
            xisr_o  = IPI_SRC;
            pprio_o = mfrr_i;
            own_v_o = 1'b0;
            raise_o = 1'b1;
        end
    end
endmodule

// File: rtl/irqp_req_arb.sv
module irqp_req_arb
    import irqp_pkg::*;
#(
    parameter int OWNER_W = 2
) (
    input  logic               req_v_i,
    input  src_t               req_src_i,
    input  prio_t              req_prio_i,
    input  logic [OWNER_W-1:0] req_own_i,
    input  prio_t              cppr_i,
    input  src_t               xisr_i,
    input  prio_t              pprio_i,
    input  logic               own_v_i,
    input  logic [OWNER_W-1:0] own_i,
    output logic               take_o,
    output src_t               xisr_o,
    output prio_t              pprio_o,
    output logic               own_v_o,
    output logic [OWNER_W-1:0] own_o,
    output logic               rej_v_o,
    output src_t               rej_src_o,
    output logic [OWNER_W-1:0] rej_own_o
);
    logic refuse;

    always_comb begin
        refuse    = (req_prio_i >= cppr_i) ||
                    ((xisr_i != '0) && (pprio_i <= req_prio_i));
        take_o    = 1'b0;
        xisr_o    = xisr_i;
        pprio_o   = pprio_i;
        own_v_o   = own_v_i;
        own_o     = own_i;
        rej_v_o   = 1'b0;
        rej_src_o = req_src_i;
        rej_own_o = req_own_i;
        if (req_v_i) begin
            if (refuse) begin
                rej_v_o = 1'b1;
            end else begin
                rej_v_o   = (xisr_i != '0) && own_v_i;
                rej_src_o = xisr_i;
                rej_own_o = own_i;
                take_o    = 1'b1;
                xisr_o    = req_src_i;
                pprio_o   = req_prio_i;
                own_v_o   = 1'b1;
                own_o     = req_own_i;
            end
        end
    end
endmodule

// File: rtl/irq_present.sv
module irq_present
    import irqp_pkg::*;
#(
    parameter int OWNER_W = 2,
    parameter int IPI_NUM = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_accept,
    input  logic                op_eoi,
    input  logic                op_cppr,
    input  logic                op_mfrr,
    input  logic                op_poll,
    input  logic [WORD_W-1:0]   op_wdata,
    input  logic                req_valid,
    input  logic [SRC_W-1:0]    req_src,
    input  logic [PRIO_W-1:0]   req_prio,
    input  logic [OWNER_W-1:0]  req_owner,
    output logic                irq_out,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_word,
    output logic [PRIO_W-1:0]   rd_mfrr,
    output logic                rej_op_valid,
    output logic [SRC_W-1:0]    rej_op_src,
    output logic [OWNER_W-1:0]  rej_op_owner,
    output logic                rej_req_valid,
    output logic [SRC_W-1:0]    rej_req_src,
    output logic [OWNER_W-1:0]  rej_req_owner,
    output logic                eoi_valid,
    output logic [SRC_W-1:0]    eoi_src,
    output logic                resend_valid
);
    typedef struct packed {
        prio_t               cppr;
        src_t                xisr;
        prio_t               pprio;
        prio_t               mfrr;
        logic                own_v;
        logic [OWNER_W-1:0]  own;
        logic                irq;
        logic                rd_v;
        logic [WORD_W-1:0]   rd_word;
        prio_t               rd_mfrr;
        logic                rop_v;
        src_t                rop_src;
        logic [OWNER_W-1:0]  rop_own;
        logic                rrq_v;
        src_t                rrq_src;
        logic [OWNER_W-1:0]  rrq_own;
        logic                eoi_v;
        src_t                eoi_src;
        logic                rs_v;
    } st_t;

    st_t st_q, st_s1, st_s2, st_d;
    logic chk_en;
    prio_t wr_prio;

    // Operation stage: at most one strobe acts, in fixed priority order.
    always_comb begin
        wr_prio       = op_wdata[PRIO_W-1:0];
        st_s1         = st_q;
        st_s1.rd_v    = 1'b0;
        st_s1.rop_v   = 1'b0;
        st_s1.rrq_v   = 1'b0;
        st_s1.eoi_v   = 1'b0;
        st_s1.rs_v    = 1'b0;
        chk_en        = 1'b0;
        if (op_accept) begin
            st_s1.rd_v    = 1'b1;
            st_s1.rd_word = {st_q.cppr, st_q.xisr};
            st_s1.rd_mfrr = st_q.mfrr;
            st_s1.irq     = 1'b0;
            st_s1.cppr    = st_q.pprio;
            st_s1.xisr    = '0;
            st_s1.pprio   = PRIO_NONE;
            st_s1.own_v   = 1'b0;
        end else if (op_eoi) begin
            st_s1.cppr    = op_wdata[WORD_W-1:SRC_W];
            st_s1.eoi_v   = 1'b1;
            st_s1.eoi_src = op_wdata[SRC_W-1:0];
            st_s1.rs_v    = (st_q.xisr == '0);
        end else if (op_cppr) begin
            st_s1.cppr = wr_prio;
            if (wr_prio < st_q.cppr) begin
                if ((st_q.xisr != '0) && (wr_prio <= st_q.pprio)) begin
                    st_s1.xisr    = '0;
                    st_s1.pprio   = PRIO_NONE;
                    st_s1.irq     = 1'b0;
                    st_s1.rop_v   = st_q.own_v;
                    st_s1.rop_src = st_q.xisr;
                    st_s1.rop_own = st_q.own;
                    st_s1.own_v   = 1'b0;
                end
            end else begin
                st_s1.rs_v = (st_q.xisr == '0);
            end
        end else if (op_mfrr) begin
            st_s1.mfrr = wr_prio;
            chk_en     = (wr_prio < st_q.cppr);
        end else if (op_poll) begin
            st_s1.rd_v    = 1'b1;
            st_s1.rd_word = {st_q.cppr, st_q.xisr};
            st_s1.rd_mfrr = st_q.mfrr;
        end
        if (st_s1.rs_v) begin
            chk_en = (st_s1.mfrr < st_s1.cppr);
        end
    end

    src_t               c_xisr, c_rej_src;
    prio_t              c_pprio;
    logic               c_own_v, c_raise, c_rej_v;
    logic [OWNER_W-1:0] c_rej_own;

    irqp_ipi_chk #(.OWNER_W(OWNER_W), .IPI_NUM(IPI_NUM)) ipi_i (
        .en_i      (chk_en),
        .xisr_i    (st_s1.xisr),
        .pprio_i   (st_s1.pprio),
        .own_v_i   (st_s1.own_v),
        .own_i     (st_s1.own),
        .mfrr_i    (st_s1.mfrr),
        .xisr_o    (c_xisr),
        .pprio_o   (c_pprio),
        .own_v_o   (c_own_v),
        .raise_o   (c_raise),
        .rej_v_o   (c_rej_v),
        .rej_src_o (c_rej_src),
        .rej_own_o (c_rej_own)
    );

    always_comb begin
        st_s2       = st_s1;
        st_s2.xisr  = c_xisr;
        st_s2.pprio = c_pprio;
        st_s2.own_v = c_own_v;
        if (c_raise) st_s2.irq = 1'b1;
        if (c_rej_v) begin
            st_s2.rop_v   = 1'b1;
            st_s2.rop_src = c_rej_src;
            st_s2.rop_own = c_rej_own;
        end
    end

    src_t               a_xisr, a_rej_src;
    prio_t              a_pprio;
    logic               a_take, a_own_v, a_rej_v;
    logic [OWNER_W-1:0] a_own, a_rej_own;

    irqp_req_arb #(.OWNER_W(OWNER_W)) arb_i (
        .req_v_i    (req_valid),
        .req_src_i  (req_src),
        .req_prio_i (req_prio),
        .req_own_i  (req_owner),
        .cppr_i     (st_s2.cppr),
        .xisr_i     (st_s2.xisr),
        .pprio_i    (st_s2.pprio),
        .own_v_i    (st_s2.own_v),
        .own_i      (st_s2.own),
        .take_o     (a_take),
        .xisr_o     (a_xisr),
        .pprio_o    (a_pprio),
        .own_v_o    (a_own_v),
        .own_o      (a_own),
        .rej_v_o    (a_rej_v),
        .rej_src_o  (a_rej_src),
        .rej_own_o  (a_rej_own)
    );

    always_comb begin
        st_d         = st_s2;
        st_d.xisr    = a_xisr;
        st_d.pprio   = a_pprio;
        st_d.own_v   = a_own_v;
        st_d.own     = a_own;
        if (a_take) st_d.irq = 1'b1;
        st_d.rrq_v   = a_rej_v;
        st_d.rrq_src = a_rej_src;
        st_d.rrq_own = a_rej_own;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pprio <= PRIO_NONE;
            st_q.mfrr  <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out       = st_q.irq;
    assign rd_valid      = st_q.rd_v;
    assign rd_word       = st_q.rd_word;
    assign rd_mfrr       = st_q.rd_mfrr;
    assign rej_op_valid  = st_q.rop_v;
    assign rej_op_src    = st_q.rop_src;
    assign rej_op_owner  = st_q.rop_own;
    assign rej_req_valid = st_q.rrq_v;
    assign rej_req_src   = st_q.rrq_src;
    assign rej_req_owner = st_q.rrq_own;
    assign eoi_valid     = st_q.eoi_v;
    assign eoi_src       = st_q.eoi_src;
    assign resend_valid  = st_q.rs_v;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker
    import irqp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_accept,
    input logic              op_eoi,
    input logic              op_cppr,
    input logic              op_mfrr,
    input logic              op_poll,
    input logic [WORD_W-1:0] op_wdata,
    input logic              req_valid,
    input logic [SRC_W-1:0]  req_src,
    input logic [PRIO_W-1:0] req_prio,
    input logic              irq_out,
    input logic              rd_valid,
    input logic              rej_req_valid,
    input logic [SRC_W-1:0]  rej_req_src,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src,
    input logic [PRIO_W-1:0] cur_cppr,
    input logic [SRC_W-1:0]  cur_src
);
    logic any_op;
    assign any_op = op_accept | op_eoi | op_cppr | op_mfrr | op_poll;

    // R12
    irq_tracks_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (cur_src != '0));

    // R5
    accept_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_accept && !req_valid) |=> !irq_out);

    // R2
    poll_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_poll && !op_accept && !op_eoi && !op_cppr && !op_mfrr && !req_valid)
        |=> ($stable(cur_src) && $stable(cur_cppr)));

    // R2
    rd_from_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(op_accept || op_poll));

    // R3
    refuse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_op && (req_prio >= cur_cppr))
        |=> (rej_req_valid && (rej_req_src == $past(req_src))));

    // R6
    eoi_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_eoi && !op_accept)
        |=> (eoi_valid && (eoi_src == $past(op_wdata[SRC_W-1:0]))));
endmodule

bind irq_present irqp_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_accept     (op_accept),
    .op_eoi        (op_eoi),
    .op_cppr       (op_cppr),
    .op_mfrr       (op_mfrr),
    .op_poll       (op_poll),
    .op_wdata      (op_wdata),
    .req_valid     (req_valid),
    .req_src       (req_src),
    .req_prio      (req_prio),
    .irq_out       (irq_out),
    .rd_valid      (rd_valid),
    .rej_req_valid (rej_req_valid),
    .rej_req_src   (rej_req_src),
    .eoi_valid     (eoi_valid),
    .eoi_src       (eoi_src),
    .cur_cppr      (st_q.cppr),
    .cur_src       (st_q.xisr)
);

// File: tb/irq_present_tb.sv
module irq_present_tb_top;
    localparam int OW = 2;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_accept = 0, op_eoi = 0, op_cppr = 0, op_mfrr = 0, op_poll = 0;
    logic [31:0] op_wdata = '0;
    logic req_valid = 0;
    logic [23:0] req_src = '0;
    logic [7:0] req_prio = '0;
    logic [OW-1:0] req_owner = '0;
    logic irq_out, rd_valid, rej_op_valid, rej_req_valid, eoi_valid, resend_valid;
    logic [31:0] rd_word;
    logic [7:0] rd_mfrr;
    logic [23:0] rej_op_src, rej_req_src, eoi_src;
    logic [OW-1:0] rej_op_owner, rej_req_owner;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_present #(.OWNER_W(OW), .IPI_NUM(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_accept(op_accept), .op_eoi(op_eoi),
        .op_cppr(op_cppr), .op_mfrr(op_mfrr), .op_poll(op_poll),
        .op_wdata(op_wdata), .req_valid(req_valid), .req_src(req_src),
        .req_prio(req_prio), .req_owner(req_owner), .irq_out(irq_out),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_mfrr(rd_mfrr),
        .rej_op_valid(rej_op_valid), .rej_op_src(rej_op_src),
        .rej_op_owner(rej_op_owner), .rej_req_valid(rej_req_valid),
        .rej_req_src(rej_req_src), .rej_req_owner(rej_req_owner),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid));

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        op_accept = 0; op_eoi = 0; op_cppr = 0; op_mfrr = 0; op_poll = 0;
        req_valid = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic set_req(logic [23:0] s, logic [7:0] p, logic [OW-1:0] o);
        req_valid = 1; req_src = s; req_prio = p; req_owner = o;
    endtask

    task automatic do_req(logic [23:0] s, logic [7:0] p, logic [OW-1:0] o);
        set_req(s, p, o); tick();
    endtask

    task automatic do_eoi(logic [31:0] w);
        op_eoi = 1; op_wdata = w; tick();
    endtask

    task automatic do_cppr(logic [7:0] v);
        op_cppr = 1; op_wdata = {24'h0, v}; tick();
    endtask

    task automatic do_mfrr(logic [7:0] v);
        op_mfrr = 1; op_wdata = {24'h0, v}; tick();
    endtask

    task automatic do_poll(string r, logic [31:0] w, logic [7:0] m);
        op_poll = 1; tick();
        chk(r, {31'h0, rd_valid}, 32'h1);
        chk(r, rd_word, w);
        chk(r, {24'h0, rd_mfrr}, {24'h0, m});
        chk({r, " R12 line"}, {31'h0, irq_out}, {31'h0, (w[23:0] != 0)});
    endtask

    logic [7:0] vals [6] = '{8'h00, 8'h02, 8'h05, 8'h08, 8'h09, 8'hFF};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
        chk("R1 notif", {27'h0, rej_op_valid, rej_req_valid, eoi_valid, resend_valid, rd_valid}, 32'h0);
        do_poll("R1 poll", 32'h0000_0000, 8'hFF);
        op_accept = 1; tick();
        chk("R1 accept word", rd_word, 32'h0);
        do_poll("R1 pprio FF", 32'hFF00_0000, 8'hFF);

        // R3 R4 sweep: processor priority x two successive requests
        for (int c = 1; c < 6; c++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    logic [7:0] cp, p1, p2, pp;
                    logic pend1, ref2;
                    logic [23:0] xs;
                    cp = vals[c]; p1 = vals[a]; p2 = vals[b];
                    do_reset();
                    do_eoi({cp, 24'h0});
                    do_req(24'd10, p1, 2'd1);
                    pend1 = (p1 < cp);
                    chk("R3 first", {31'h0, rej_req_valid}, {31'h0, !pend1});
                    do_req(24'd20, p2, 2'd2);
                    ref2 = (p2 >= cp) || (pend1 && (p1 <= p2));
                    chk("R3/R4 reject", {31'h0, rej_req_valid}, {31'h0, ref2 || pend1});
                    if (ref2) chk("R3 src", {8'h0, rej_req_src}, 32'd20);
                    else if (pend1) begin
                        chk("R4 displaced", {8'h0, rej_req_src}, 32'd10);
                        chk("R4 owner", {30'h0, rej_req_owner}, 32'd1);
                    end
                    xs = !ref2 ? 24'd20 : (pend1 ? 24'd10 : 24'd0);
                    pp = !ref2 ? p2 : (pend1 ? p1 : 8'hFF);
                    do_poll("R2/R4 state", {cp, xs}, 8'hFF);
                    op_accept = 1; tick();
                    chk("R5 word", rd_word, {cp, xs});
                    chk("R5 line", {31'h0, irq_out}, 32'h0);
                    do_poll("R5 after", {pp, 24'h0}, 8'hFF);
                end
            end
        end

        // R7 R8 sweep: processor priority write over a pending source
        for (int n = 0; n < 6; n++) begin
            for (int a = 1; a < 5; a++) begin
                logic [7:0] nv, p;
                logic pend, drop;
                nv = vals[n]; p = vals[a];
                do_reset();
                do_eoi(32'h0800_0000);
                do_req(24'd10, p, 2'd1);
                pend = (p < 8'h08);
                do_cppr(nv);
                drop = (nv < 8'h08) && pend && (nv <= p);
                chk("R7 reject", {31'h0, rej_op_valid}, {31'h0, drop});
                if (drop) chk("R7 src", {8'h0, rej_op_src}, 32'd10);
                chk("R8 resend", {31'h0, resend_valid}, {31'h0, (nv >= 8'h08) && !pend});
                do_poll("R7 state", {nv, (pend && !drop) ? 24'd10 : 24'd0}, 8'hFF);
            end
        end

        // R6 eoi forwarding with and without pending source
        do_reset();
        do_eoi(32'h0800_0000);
        do_req(24'd10, 8'h05, 2'd1);
        do_eoi(32'h0A12_3456);
        chk("R6 eoi", {31'h0, eoi_valid}, 32'h1);
        chk("R6 src", {8'h0, eoi_src}, 32'h0012_3456);
        chk("R6 no resend", {31'h0, resend_valid}, 32'h0);
        do_poll("R6 cppr", 32'h0A00_000A, 8'hFF);

        // R9 IPI check
        do_reset();
        do_eoi(32'h0800_0000);
        do_req(24'd10, 8'h05, 2'd1);
        do_mfrr(8'h06);
        chk("R9 kept", {31'h0, rej_op_valid}, 32'h0);
        do_poll("R9 kept state", 32'h0800_000A, 8'h06);
        do_mfrr(8'h03);
        chk("R9 reject", {31'h0, rej_op_valid}, 32'h1);
        chk("R9 src", {8'h0, rej_op_src}, 32'd10);
        do_poll("R9 ipi", 32'h0800_0002, 8'h03);
        do_req(24'd30, 8'h01, 2'd3);
        chk("R4 ipi no reject", {31'h0, rej_req_valid}, 32'h0);
        do_poll("R4 over ipi", 32'h0800_001E, 8'h03);
        do_mfrr(8'h09);
        do_poll("R9 not below", 32'h0800_001E, 8'h09);

        // R10 resend runs the IPI check
        do_reset();
        do_mfrr(8'h05);
        do_poll("R10 idle", 32'h0000_0000, 8'h05);
        do_eoi(32'hFF00_0000);
        chk("R10 resend", {31'h0, resend_valid}, 32'h1);
        do_poll("R10 ipi", 32'hFF00_0002, 8'h05);

        // R11 same cycle: priority write then request
        do_reset();
        do_eoi(32'h0800_0000);
        do_req(24'd10, 8'h05, 2'd1);
        op_cppr = 1; op_wdata = 32'h04; set_req(24'd20, 8'h02, 2'd2); tick();
        chk("R11 op reject", {31'h0, rej_op_valid}, 32'h1);
        chk("R11 op src", {8'h0, rej_op_src}, 32'd10);
        chk("R11 no req reject", {31'h0, rej_req_valid}, 32'h0);
        do_poll("R11 state", 32'h0400_0014, 8'hFF);
        // R11 same cycle: accept then request
        do_reset();
        do_eoi(32'h0800_0000);
        do_req(24'd10, 8'h05, 2'd1);
        op_accept = 1; set_req(24'd20, 8'h06, 2'd2); tick();
        chk("R11 accept word", rd_word, 32'h0800_000A);
        chk("R11 req reject", {31'h0, rej_req_valid}, 32'h1);
        chk("R11 req src", {8'h0, rej_req_src}, 32'd20);
        do_poll("R11 after", 32'h0500_0000, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule